// File: doc/BRIEF.md
# Packed Nibble Tag Store Engine

This block writes 4-bit allocation tags into a byte-wide tag memory. Each memory byte holds the tags of two neighbouring 16-byte data granules, so one byte covers a 32-byte span of data addresses. A client issues one command at a time. The command carries an operation, a data byte address, a tag value, a block-size exponent and a flag saying that the target page carries no tags. The engine then drives a simple synchronous RAM port until the command is finished. The RAM returns read data one cycle after a read strobe.

Three operations are supported. The first stores one granule's tag. The second stores the same tag into two adjacent granules. The third fills a whole zeroing block with a tag. The engine decides between a nibble read-modify-write and a whole-byte write from the address alignment. A two-granule store that starts in the upper half of a byte is split across two bytes. Each read-modify-write runs as one uninterrupted sequence.

Top module: `tag_store_engine`

## Requirements
- R1: The tag byte for data address A sits at memory index A >> 5. Address bit 4 picks the nibble: 0 selects bits 3:0 and 1 selects bits 7:4.
- R2: A single store (op 0) or a pair store (op 1) whose address bits 3:0 are not all zero finishes with done and fault both high in the first cycle after acceptance, and writes nothing.
- R3: An aligned single store (op 0) reads the target byte, then writes it back one cycle later to the same index. Only the selected nibble is replaced with the tag and the other nibble keeps its old value.
- R4: A pair store (op 1) with address bits 4:0 all zero performs exactly one write of the tag in both nibbles and no read. It finishes in the first cycle after acceptance.
- R5: A pair store (op 1) with bit 4 set and bits 3:0 clear replaces the upper nibble of byte A >> 5 and the lower nibble of the following byte. Both other nibbles are preserved.
- R6: A block fill (op 2) with exponent L writes the tag in both nibbles into 2^(L-5) consecutive bytes. It writes one byte per cycle, starting at the address rounded down to a 2^L boundary. Exponents below 5 are treated as 5. No alignment fault applies.
- R7: When the untagged flag is high, a command that is not misaligned finishes with done in the first cycle after acceptance, with no write and no fault. A misaligned store still faults.
- R8: Every accepted command raises done for exactly one cycle. The ready output is high only while idle, and a command offered while busy is ignored.
- R9: Op 3 is reserved. It finishes with done in the first cycle after acceptance, with no write and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered; taken when ready is high |
| cmdOp | input | 2 | 0 single, 1 pair, 2 block fill, 3 reserved |
| cmdAddr | input | ADDR_W | Data byte address |
| cmdTag | input | 4 | Tag value to store |
| cmdBlkLog2 | input | LG_W | Fill block size exponent |
| cmdUntagged | input | 1 | Target page carries no tags |
| ready | output | 1 | Engine idle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, valid with done |
| memAddr | output | ADDR_W-5 | Tag memory byte index |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, one cycle after memRd |

## Verification
Single and pair stores are swept over every byte offset of 128 consecutive addresses. This covers both nibble positions, the aligned versus split pair paths, and all misaligned offsets that must fault. A shadow copy of the whole memory shows whether the neighbouring nibble survives. Fills run at every exponent from 0 to 10, and once at the largest, from unaligned addresses. These runs separate the rounding of the base, the byte count and the clamping of small exponents. Untagged and reserved commands, and a command offered while a fill is running, show that the memory and the done pulse count are left untouched.

// File: rtl/tagst_pkg.sv
package tagst_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    OP_SINGLE = 2'd0,
    OP_PAIR   = 2'd1,
    OP_FILL   = 2'd2,
    OP_RSVD   = 2'd3
  } tagOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic rd;
    logic wr;
    logic whole;
    logic nibHi;
  } ctlStrb_t;

  localparam int SPAN_LOG2 = 5;  // 32 data bytes per tag byte
endpackage

// File: rtl/tagst_dpath.sv
module tagst_dpath
  import tagst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LG_W   = 4,
  localparam int IDX_W = ADDR_W - SPAN_LOG2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic [3:0]       cmdTag,
  input  logic [LG_W-1:0]  cmdBlkLog2,
  input  logic             cmdFill,
  input  logic [7:0]       memRdata,
  output logic [IDX_W-1:0] memAddr,
  output logic [7:0]       memWdata,
  output logic             cntLast
);
  localparam logic [LG_W-1:0] MIN_LG = LG_W'(SPAN_LOG2);

  logic [IDX_W-1:0] idxQ, cntQ;
  logic [3:0]       tagQ;
  logic [LG_W-1:0]  lgClamp, shAmt;
  logic [IDX_W-1:0] spanMask;

  always_comb begin
    lgClamp  = (cmdBlkLog2 < MIN_LG) ? MIN_LG : cmdBlkLog2;
    shAmt    = lgClamp - MIN_LG;
    spanMask = {IDX_W{1'b1}} << shAmt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      cntQ <= '0;
      tagQ <= '0;
    end else if (strb.load) begin
      tagQ <= cmdTag;
      if (cmdFill) begin
        idxQ <= cmdIdx & spanMask;
        cntQ <= ~spanMask;
      end else begin
        idxQ <= cmdIdx;
        cntQ <= '0;
      end
    end else if (strb.step) begin
      idxQ <= idxQ + 1'b1;
      cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    if (strb.whole)      memWdata = {tagQ, tagQ};
    else if (strb.nibHi) memWdata = {tagQ, memRdata[3:0]};
    else                 memWdata = {memRdata[7:4], tagQ};
  end

  assign memAddr = idxQ;
  assign cntLast = (cntQ == '0);
endmodule

// File: rtl/tagst_ctrl.sv
module tagst_ctrl
  import tagst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [4:0] cmdLow,
  input  logic       cmdUntagged,
  input  logic       cntLast,
  output ctlStrb_t   strb,
  output logic       ready,
  output logic       done,
  output logic       fault
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_MRG, ST_FILL, ST_END
  } state_e;

  state_e stQ, stD;
  logic   hiQ, hiD, pendQ, pendD, faultQ, faultD;
  tagOp_e op;
  logic   misal;

  assign op    = tagOp_e'(cmdOp);
  assign misal = (cmdLow[3:0] != 4'd0);

  always_comb begin
    stD    = stQ;
    hiD    = hiQ;
    pendD  = pendQ;
    faultD = faultQ;
    strb   = '0;
    done   = 1'b0;
    unique case (stQ)
      ST_IDLE: begin
        faultD = 1'b0;
        if (cmdValid) begin
          strb.load = 1'b1;
          if (op == OP_RSVD) begin
            stD = ST_END;
          end else if (op != OP_FILL && misal) begin
            faultD = 1'b1;
            stD    = ST_END;
          end else if (cmdUntagged) begin
            stD = ST_END;
          end else if (op == OP_SINGLE) begin
            hiD   = cmdLow[4];
            pendD = 1'b0;
            stD   = ST_RD;
          end else if (op == OP_PAIR && cmdLow[4]) begin
            hiD   = 1'b1;
            pendD = 1'b1;
            stD   = ST_RD;
          end else begin
            stD = ST_FILL;
          end
        end
      end
      ST_RD: begin
        strb.rd = 1'b1;
        stD     = ST_MRG;
      end
      ST_MRG: begin
        strb.wr    = 1'b1;
        strb.nibHi = hiQ;
        if (pendQ) begin
          strb.step = 1'b1;
          pendD     = 1'b0;
          hiD       = 1'b0;
          stD       = ST_RD;
        end else begin
          done = 1'b1;
          stD  = ST_IDLE;
        end
      end
      ST_FILL: begin
        strb.wr    = 1'b1;
        strb.whole = 1'b1;
        if (cntLast) begin
          done = 1'b1;
          stD  = ST_IDLE;
        end else begin
          strb.step = 1'b1;
        end
      end
      ST_END: begin
        done = 1'b1;
        stD  = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      hiQ    <= 1'b0;
      pendQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      stQ    <= stD;
      hiQ    <= hiD;
      pendQ  <= pendD;
      faultQ <= faultD;
    end
  end

  assign ready = (stQ == ST_IDLE);
  assign fault = (stQ == ST_END) && faultQ;
endmodule

// File: rtl/tag_store_engine.sv
module tag_store_engine
  import tagst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LG_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [1:0]                  cmdOp,
  input  logic [ADDR_W-1:0]           cmdAddr,
  input  logic [3:0]                  cmdTag,
  input  logic [LG_W-1:0]             cmdBlkLog2,
  input  logic                        cmdUntagged,
  output logic                        ready,
  output logic                        done,
  output logic                        fault,
  output logic [ADDR_W-SPAN_LOG2-1:0] memAddr,
  output logic                        memRd,
  output logic                        memWr,
  output logic [7:0]                  memWdata,
  input  logic [7:0]                  memRdata
);
  ctlStrb_t strb;
  logic     cntLast;

  tagst_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .cmdLow      (cmdAddr[4:0]),
    .cmdUntagged (cmdUntagged),
    .cntLast     (cntLast),
    .strb        (strb),
    .ready       (ready),
    .done        (done),
    .fault       (fault)
  );

  tagst_dpath #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdIdx     (cmdAddr[ADDR_W-1:SPAN_LOG2]),
    .cmdTag     (cmdTag),
    .cmdBlkLog2 (cmdBlkLog2),
    .cmdFill    (cmdOp == OP_FILL),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .cntLast    (cntLast)
  );

  assign memRd = strb.rd;
  assign memWr = strb.wr;
endmodule

// File: rtl/tagst_chk.sv
module tagst_chk #(
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic [4:0]       cmdLow,
  input logic [3:0]       cmdTag,
  input logic             cmdUntagged,
  input logic             ready,
  input logic             done,
  input logic             fault,
  input logic [IDX_W-1:0] memAddr,
  input logic             memRd,
  input logic             memWr,
  input logic [7:0]       memWdata
);
  timeunit 1ns;
  timeprecision 1ps;

  logic accept, misal;
  assign accept = cmdValid && ready;
  assign misal  = (cmdOp != 2'd2) && (cmdOp != 2'd3) && (cmdLow[3:0] != 4'd0);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R3
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> memWr && $stable(memAddr)); // R3
  AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    accept && misal |=> done && fault && !memWr); // R2
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done); // R2
  AST_PAIR_WHOLE: assert property (@(posedge clk) disable iff (!rstN)
    accept && cmdOp == 2'd1 && cmdLow == 5'd0 && !cmdUntagged
      |=> memWr && !memRd && done && memWdata == {2{$past(cmdTag)}}); // R4
  AST_UNTAGGED_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    accept && cmdUntagged && !misal && cmdOp != 2'd3
      |=> done && !fault && !memWr); // R7
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ready); // R8
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ready); // R8
  AST_RSVD_OP: assert property (@(posedge clk) disable iff (!rstN)
    accept && cmdOp == 2'd3 |=> done && !fault && !memWr); // R9
endmodule

bind tag_store_engine tagst_chk #(.IDX_W(ADDR_W - 5)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdOp       (cmdOp),
  .cmdLow      (cmdAddr[4:0]),
  .cmdTag      (cmdTag),
  .cmdUntagged (cmdUntagged),
  .ready       (ready),
  .done        (done),
  .fault       (fault),
  .memAddr     (memAddr),
  .memRd       (memRd),
  .memWr       (memWr),
  .memWdata    (memWdata)
);

// File: tb/sim_tag_store_engine.sv
module sim_tag_store_engine;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 16;
  localparam int LG_W   = 4;
  localparam int IDX_W  = ADDR_W - 5;
  localparam int DEPTH  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [1:0]       cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [3:0]       cmdTag = '0;
  logic [LG_W-1:0]  cmdBlkLog2 = '0;
  logic             cmdUntagged = 1'b0;
  logic             ready, done, fault, memRd, memWr;
  logic [IDX_W-1:0] memAddr;
  logic [7:0]       memWdata, memRdata;

  logic [7:0] ram [DEPTH];
  logic [7:0] refMem [DEPTH];
  int nChk = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tag_store_engine #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdTag(cmdTag), .cmdBlkLog2(cmdBlkLog2),
    .cmdUntagged(cmdUntagged), .ready(ready), .done(done), .fault(fault),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= 8'(i * 37 + 5);
    end else begin
      if (memWr) ram[memAddr] <= memWdata;
      if (memRd) memRdata <= ram[memAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmpMem(input string req);
    int bad = 0;
    int badIdx = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (ram[i] !== refMem[i]) begin
        bad++;
        if (badIdx < 0) badIdx = i;
      end
    end
    if (badIdx < 0) chk(1'b1, req, "memory", 0, 0);
    else chk(1'b0, req, $sformatf("memory byte %0d", badIdx),
             int'(ram[badIdx]), int'(refMem[badIdx]));
  endtask

  task automatic runCmd(input int op, input int addr, input int tag,
                        input int lg, input bit untag);
    bit misal = (op < 2) && ((addr % 16) != 0);
    int idx = (addr >> 5) % DEPTH;
    int expWr = 0, expRd = 0, expLat = 1, expFault = 0;
    int nw = 0, nr = 0, cyc = 0, gotFault = 0;
    string req;
    if (op == 3) req = "R9";
    else if (misal) begin req = "R2"; expFault = 1; end
    else if (untag) req = "R7";
    else if (op == 0) begin
      req = "R3"; expWr = 1; expRd = 1; expLat = 2;
      if ((addr & 16) != 0) refMem[idx][7:4] = 4'(tag);
      else refMem[idx][3:0] = 4'(tag);
    end else if (op == 1) begin
      if ((addr & 16) != 0) begin
        req = "R5"; expWr = 2; expRd = 2; expLat = 4;
        refMem[idx][7:4] = 4'(tag);
        refMem[(idx + 1) % DEPTH][3:0] = 4'(tag);
      end else begin
        req = "R4"; expWr = 1;
        refMem[idx] = {4'(tag), 4'(tag)};
      end
    end else begin
      int e = (lg < 5) ? 5 : lg;
      int n = 1 << (e - 5);
      int base = ((addr >> e) << e) >> 5;
      req = "R6"; expWr = n; expLat = n;
      for (int k = 0; k < n; k++) refMem[(base + k) % DEPTH] = {4'(tag), 4'(tag)};
    end

    @(negedge clk);
    chk(ready == 1'b1, "R8", "ready before command", int'(ready), 1);
    cmdOp = 2'(op); cmdAddr = ADDR_W'(addr); cmdTag = 4'(tag);
    cmdBlkLog2 = LG_W'(lg); cmdUntagged = untag; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    forever begin
      cyc++;
      nw += int'(memWr);
      nr += int'(memRd);
      if (done) begin gotFault = int'(fault); break; end
      if (cyc > 5000) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    chk(cyc == expLat, req, $sformatf("cycles op%0d addr%0h", op, addr), cyc, expLat);
    chk(nw == expWr, req, $sformatf("writes op%0d addr%0h", op, addr), nw, expWr);
    chk(nr == expRd, req, $sformatf("reads op%0d addr%0h", op, addr), nr, expRd);
    chk(gotFault == expFault, req, $sformatf("fault op%0d addr%0h", op, addr),
        gotFault, expFault);
    cmpMem(req);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      nChk++;
      nErr++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    // reset state (R8)
    chk(ready == 1'b1, "R8", "reset ready", int'(ready), 1);
    chk(done == 1'b0, "R8", "reset done", int'(done), 0);
    chk(memWr == 1'b0, "R8", "reset memWr", int'(memWr), 0);
    chk(memRd == 1'b0, "R8", "reset memRd", int'(memRd), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // single stores over every offset (R1, R2, R3)
    for (int a = 0; a < 128; a++) runCmd(0, 256 + a, (a * 5 + 1) & 15, 0, 1'b0);
    // highest index, upper nibble (R1)
    runCmd(0, 16'hFFF0, 9, 0, 1'b0);
    // pair stores over every offset (R2, R4, R5)
    for (int a = 0; a < 128; a++) runCmd(1, 1024 + a, (a * 3 + 7) & 15, 0, 1'b0);
    // fills at each exponent, unaligned start (R6)
    for (int lg = 0; lg <= 10; lg++) runCmd(2, 3000 + lg * 611, lg + 2, lg, 1'b0);
    runCmd(2, 16'h1234, 6, 15, 1'b0);
    runCmd(0, 16'h0030, 11, 0, 1'b0);
    // untagged pages (R7)
    runCmd(0, 16'h0040, 3, 0, 1'b1);
    runCmd(1, 16'h0050, 4, 0, 1'b1);
    runCmd(2, 16'h0200, 5, 7, 1'b1);
    runCmd(0, 16'h0041, 6, 0, 1'b1);
    // reserved op (R9)
    runCmd(3, 16'h0060, 7, 6, 1'b0);

    // command offered while busy is ignored (R8)
    begin
      int doneCnt = 0;
      int cyc = 0;
      for (int k = 0; k < 4; k++) refMem[(16'h0800 >> 5) + k] = 8'hDD;
      @(negedge clk);
      cmdOp = 2'd2; cmdAddr = 16'h0800; cmdTag = 4'hD; cmdBlkLog2 = 4'd7;
      cmdUntagged = 1'b0; cmdValid = 1'b1;
      @(negedge clk);
      cmdOp = 2'd0; cmdAddr = 16'h0010; cmdTag = 4'h1;
      forever begin
        cyc++;
        doneCnt += int'(done);
        if (done) break;
        if (cyc > 100) break;
        @(negedge clk);
      end
      cmdValid = 1'b0;
      repeat (3) begin
        @(negedge clk);
        doneCnt += int'(done);
      end
      chk(doneCnt == 1, "R8", "done pulses while busy", doneCnt, 1);
      chk(cyc == 4, "R8", "fill cycles while busy", cyc, 4);
      cmpMem("R8");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule